// File: doc/BRIEF.md
# Wait-on-Reservation Stall Controller

This block holds a hart in a low-power wait while it polls a memory location. Software first runs a load-reserved, which records the address granule as a reservation. It then issues one of two wait instructions. The block decodes the instruction word presented at issue. If a reservation is live and no interrupt is pending, it raises `stall` and `lp_req` until a release condition arrives. The release conditions are:

- a store that hits the reservation granule;
- any pending interrupt bit, whether or not that interrupt is enabled;
- a spurious-wake strobe, which models the implementation's freedom to end the wait at any time;
- for the timed variant only, expiry of a short timeout.

The untimed variant can escalate to an exception instead of completing. This happens when the wait runs past a bounded limit while a timeout-wait control bit governs the current privilege mode. Under machine control outside M mode the result is an illegal-instruction request. Under hypervisor control in a virtualized mode, with the machine bit clear, the result is a virtual-instruction request.

A small single-entry reservation tracker is built in. It is armed by load-reserved and cleared by a store to the same granule.

The block has no data stream, so every pin is a plain control or status signal. While `stall` is high the pipeline must hold and present no new issue. An issue strobe that arrives during a wait is not accepted.

Top module: `wrs_stall_ctrl`

## Requirements
- R1: An issue is recognised only when all of these hold: `instr[6:0]` = 0x73; `instr[11:7]`, `instr[14:12]` and `instr[19:15]` are zero; and `instr[31:20]` is 0x00D (untimed) or 0x01D (timed). Any other word causes no stall and no completion.
- R2: If, at issue, the reservation is not live or any `irq_pend` bit is set, `done` pulses in the next cycle and `stall` stays low.
- R3: Otherwise `stall` and `lp_req` rise in the cycle after issue and stay equal for the whole wait.
- R4: A store whose address bits above the granule (`addr >> GRAN_LG2`) match the reservation clears the reservation. During a wait, such a store drops `stall` and pulses `done` in the next cycle. A store to another granule has no effect.
- R5: Any set `irq_pend` bit during a wait ends it the same way, with `done`.
- R6: `spur_wake` during a wait ends it the same way, with `done`.
- R7: With nothing else releasing it, a timed wait keeps `stall` high for exactly STO_CYC cycles and then pulses `done`. It never raises an exception, whatever the control bits are.
- R8: Take an untimed wait issued with `tw_m`=1 and `priv`≠M, where `priv` uses the encoding 0=U, 1=S, 3=M. After TRAP_CYC stalled cycles it ends with `exc_vld` and `exc_cause`=2, and with no `done`.
- R9: Take an untimed wait issued with `virt`=1, `vtw_h`=1, `tw_m`=0 and `priv`≠M. After TRAP_CYC stalled cycles it ends with `exc_vld` and `exc_cause`=22.
- R10: An untimed wait never traps in M mode. It also never traps when its governing control bits are clear, including in U mode. In these cases the wait outlasts TRAP_CYC.
- R11: `done` and `exc_vld` are never high together. `stall` falls exactly in the cycle one of them pulses. `exc_cause` is 0 whenever `exc_vld` is low.
- R12: A load-reserved in the same cycle as a hitting store leaves the reservation set. A completed wait does not clear the reservation. If a release condition is present in the cycle the trap limit is reached, the wait completes with `done` and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Instruction word presented for issue |
| instr | input | 32 | Instruction word |
| priv | input | 2 | Privilege mode (0 U, 1 S, 3 M) |
| virt | input | 1 | Hart runs virtualized (VS/VU) |
| tw_m | input | 1 | Machine timeout-wait control bit |
| vtw_h | input | 1 | Hypervisor timeout-wait control bit |
| lr_vld | input | 1 | Load-reserved executes |
| lr_addr | input | AW | Load-reserved address |
| st_vld | input | 1 | Snooped store seen |
| st_addr | input | AW | Snooped store address |
| irq_pend | input | NIRQ | Pending interrupts, enabled or not |
| spur_wake | input | 1 | Implementation-chosen early wake |
| stall | output | 1 | Hart held in wait |
| lp_req | output | 1 | Low-power request |
| done | output | 1 | One-cycle completion pulse |
| exc_vld | output | 1 | One-cycle exception request |
| exc_cause | output | 5 | Exception cause (2 illegal, 22 virtual) |

## Verification
The hardest case to reach is the collision at the trap limit. A release condition has to land in exactly the stalled cycle where the untimed counter reaches TRAP_CYC. Only then does the bench show that completion takes precedence over the exception. The stimulus issues the wait and then counts TRAP_CYC-1 further falling edges before raising an interrupt for a single cycle. A behavioural model compares every output on every clock, so the cycle-exact stall lengths of both timers are checked as well.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam logic [6:0]  OPC_SYSTEM = 7'h73;
  localparam logic [11:0] FN_UNTIMED = 12'h00D;
  localparam logic [11:0] FN_TIMED   = 12'h01D;
  localparam logic [1:0]  PRV_M      = 2'b11;
  localparam logic [4:0]  CAUSE_ILL  = 5'd2;
  localparam logic [4:0]  CAUSE_VIRT = 5'd22;

  typedef enum logic [1:0] {TRAP_NONE, TRAP_ILL, TRAP_VIRT} trap_kind_e;
  typedef enum logic {ST_IDLE, ST_WAIT} wait_st_e;

  typedef struct packed {
    logic hit;
    logic timed;
  } wrs_dec_t;
endpackage

// File: rtl/wrs_decode.sv
module wrs_decode
  import wrs_pkg::*;
(
  input  logic [31:0] instr,
  output wrs_dec_t    dec
);
  logic zero_regs;
  always_comb begin
    zero_regs = (instr[11:7] == 5'd0) && (instr[14:12] == 3'd0) && (instr[19:15] == 5'd0);
    dec.hit   = (instr[6:0] == OPC_SYSTEM) && zero_regs &&
                ((instr[31:20] == FN_UNTIMED) || (instr[31:20] == FN_TIMED));
    dec.timed = (instr[31:20] == FN_TIMED);
  end
endmodule

// File: rtl/wrs_resv_tracker.sv
module wrs_resv_tracker #(
  parameter int AW       = 32,
  parameter int GRAN_LG2 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_vld,
  input  logic [AW-1:0] lr_addr,
  input  logic          st_vld,
  input  logic [AW-1:0] st_addr,
  output logic          resv_vld,
  output logic          hit_now
);
  localparam int TAGW = AW - GRAN_LG2;

  logic [TAGW-1:0] tag_q;

  assign hit_now = resv_vld && st_vld && (st_addr[AW-1:GRAN_LG2] == tag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_vld <= 1'b0;
      tag_q    <= '0;
    end else if (lr_vld) begin
      resv_vld <= 1'b1;
      tag_q    <= lr_addr[AW-1:GRAN_LG2];
    end else if (hit_now) begin
      resv_vld <= 1'b0;
    end
  end

  assert_hit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_now && !lr_vld) |=> !resv_vld);
  assert_lr_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lr_vld |=> resv_vld);
endmodule

// File: rtl/wrs_wait_timer.sv
module wrs_wait_timer #(
  parameter int STO_CYC  = 256,
  parameter int TRAP_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sto_due,
  output logic trap_due
);
  localparam int MAXC = (STO_CYC > TRAP_CYC) ? STO_CYC : TRAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STO_LAST  = CW'(STO_CYC - 1);
  localparam logic [CW-1:0] TRAP_LAST = CW'(TRAP_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP   = CW'(MAXC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (start)                 cnt_q <= '0;
    else if (run && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign sto_due  = (cnt_q == STO_LAST);
  assign trap_due = (cnt_q == TRAP_LAST);
endmodule

// File: rtl/wrs_stall_ctrl.sv
module wrs_stall_ctrl
  import wrs_pkg::*;
#(
  parameter int AW       = 32,
  parameter int GRAN_LG2 = 6,
  parameter int NIRQ     = 16,
  parameter int STO_CYC  = 256,
  parameter int TRAP_CYC = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_vld,
  input  logic [31:0]     instr,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            tw_m,
  input  logic            vtw_h,
  input  logic            lr_vld,
  input  logic [AW-1:0]   lr_addr,
  input  logic            st_vld,
  input  logic [AW-1:0]   st_addr,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            spur_wake,
  output logic            stall,
  output logic            lp_req,
  output logic            done,
  output logic            exc_vld,
  output logic [4:0]      exc_cause
);
  wrs_dec_t   dec;
  logic       resv_vld, hit_now, resv_live, irq_any;
  logic       sto_due, trap_due;
  wait_st_e   st_q;
  logic       timed_q;
  trap_kind_e trap_q, trap_issue;
  logic       accept, can_wait, go_wait, release_now, trap_now;
  logic       done_q, exc_q;
  logic [4:0] cause_q;

  wrs_decode u_dec (.instr(instr), .dec(dec));

  wrs_resv_tracker #(.AW(AW), .GRAN_LG2(GRAN_LG2)) u_resv (
    .clk(clk), .rst_n(rst_n), .lr_vld(lr_vld), .lr_addr(lr_addr),
    .st_vld(st_vld), .st_addr(st_addr), .resv_vld(resv_vld), .hit_now(hit_now)
  );

  wrs_wait_timer #(.STO_CYC(STO_CYC), .TRAP_CYC(TRAP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(go_wait), .run(st_q == ST_WAIT),
    .sto_due(sto_due), .trap_due(trap_due)
  );

  always_comb begin
    irq_any   = |irq_pend;
    resv_live = resv_vld && !hit_now;
    accept    = (st_q == ST_IDLE) && issue_vld && dec.hit;
    can_wait  = resv_live && !irq_any;
    go_wait   = accept && can_wait;
    release_now = (st_q == ST_WAIT) &&
                  (!resv_live || irq_any || spur_wake || (timed_q && sto_due));
    trap_now  = (st_q == ST_WAIT) && !release_now && (trap_q != TRAP_NONE) && trap_due;
    // escalation policy chosen at issue: machine bit first, then hypervisor bit
    if (dec.timed || priv == PRV_M) trap_issue = TRAP_NONE;
    else if (tw_m)                  trap_issue = TRAP_ILL;
    else if (virt && vtw_h)         trap_issue = TRAP_VIRT;
    else                            trap_issue = TRAP_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      timed_q <= 1'b0;
      trap_q  <= TRAP_NONE;
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      done_q  <= (accept && !can_wait) || release_now;
      exc_q   <= trap_now;
      cause_q <= !trap_now ? 5'd0 : (trap_q == TRAP_ILL) ? CAUSE_ILL : CAUSE_VIRT;
      if (go_wait) begin
        st_q    <= ST_WAIT;
        timed_q <= dec.timed;
        trap_q  <= trap_issue;
      end else if (release_now || trap_now) begin
        st_q <= ST_IDLE;
      end
    end
  end

  assign stall     = (st_q == ST_WAIT);
  assign lp_req    = stall;
  assign done      = done_q;
  assign exc_vld   = exc_q;
  assign exc_cause = cause_q;

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc_vld));
  assert_fall_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (done || exc_vld));
  assert_irq_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && irq_any) |=> (!stall && done));
  assert_exc_after_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> $past(stall));
  assert_timed_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && timed_q) |=> !exc_vld);
  assert_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !can_wait) |=> (done && !stall));
endmodule

// File: tb/sim_wrs_stall_ctrl.sv
module sim_wrs_stall_ctrl;
  localparam int CLK_PER = 10;
  localparam int AW = 32, GL = 6, NIRQ = 16, STO = 256, TRAP = 1024;
  localparam logic [31:0] W_UNT = 32'h00D0_0073;
  localparam logic [31:0] W_TIM = 32'h01D0_0073;
  localparam logic [31:0] W_BAD = 32'h00D0_8073;

  logic clk = 0, rst_n = 0;
  logic issue_vld = 0, virt = 0, tw_m = 0, vtw_h = 0;
  logic lr_vld = 0, st_vld = 0, spur_wake = 0;
  logic [31:0] instr = '0;
  logic [1:0]  priv = 2'd0;
  logic [AW-1:0] lr_addr = '0, st_addr = '0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic stall, lp_req, done, exc_vld;
  logic [4:0] exc_cause;

  int tests = 0, fails = 0;
  string cur_req = "R3";
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  wrs_stall_ctrl #(.AW(AW), .GRAN_LG2(GL), .NIRQ(NIRQ), .STO_CYC(STO), .TRAP_CYC(TRAP)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .instr(instr), .priv(priv),
    .virt(virt), .tw_m(tw_m), .vtw_h(vtw_h), .lr_vld(lr_vld), .lr_addr(lr_addr),
    .st_vld(st_vld), .st_addr(st_addr), .irq_pend(irq_pend), .spur_wake(spur_wake),
    .stall(stall), .lp_req(lp_req), .done(done), .exc_vld(exc_vld), .exc_cause(exc_cause)
  );

  // behavioural reference model
  bit m_resv, m_wait, m_timed, m_done, m_exc;
  int m_tag, m_cnt, m_trap, m_cause;

  function automatic bit is_wait_insn(input logic [31:0] w);
    return w == W_UNT || w == W_TIM;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_resv = 0; m_wait = 0; m_done = 0; m_exc = 0; m_cause = 0; m_cnt = 0;
    end else begin
      bit hit, live, irq, nd, ne;
      int nc;
      hit  = m_resv && st_vld && (int'(st_addr >> GL) == m_tag);
      live = m_resv && !hit;
      irq  = (irq_pend != 0);
      nd = 0; ne = 0; nc = 0;
      if (m_wait) begin
        if (!live || irq || spur_wake || (m_timed && m_cnt == STO - 1)) begin
          m_wait = 0; nd = 1;
        end else if (m_trap != 0 && m_cnt == TRAP - 1) begin
          m_wait = 0; ne = 1; nc = (m_trap == 1) ? 2 : 22;
        end else m_cnt++;
      end else if (issue_vld && is_wait_insn(instr)) begin
        if (!live || irq) nd = 1;
        else begin
          m_wait = 1; m_cnt = 0; m_timed = (instr == W_TIM);
          if (m_timed || priv == 2'd3) m_trap = 0;
          else if (tw_m) m_trap = 1;
          else if (virt && vtw_h) m_trap = 2;
          else m_trap = 0;
        end
      end
      if (lr_vld) begin m_resv = 1; m_tag = int'(lr_addr >> GL); end
      else if (hit) m_resv = 0;
      m_done = nd; m_exc = ne; m_cause = nc;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(cur_req, {stall, lp_req, done, exc_vld, exc_cause},
        {m_wait, m_wait, m_done, m_exc, 5'(m_cause)}, "model compare {stall,lp,done,exc,cause}");
  end

  task automatic issue(input logic [31:0] w);
    instr = w; issue_vld = 1; @(negedge clk); issue_vld = 0; instr = '0;
  endtask
  task automatic lr(input logic [31:0] a);
    lr_addr = a; lr_vld = 1; @(negedge clk); lr_vld = 0;
  endtask
  task automatic store(input logic [31:0] a);
    st_addr = a; st_vld = 1; @(negedge clk); st_vld = 0;
  endtask
  task automatic wake_spur();
    spur_wake = 1; @(negedge clk); spur_wake = 0;
  endtask
  task automatic count_stall(output int n);
    n = 0;
    while (stall && n < 5000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3", {stall, done, exc_vld}, 0, "reset state");

    cur_req = "R1"; lr(32'h1040);
    issue(W_BAD); @(negedge clk);
    chk("R1", {stall, done}, 0, "malformed word ignored");
    issue(32'h00D0_00F3); chk("R1", {stall, done}, 0, "rd nonzero ignored");
    @(negedge clk);

    cur_req = "R4"; issue(W_UNT);
    chk("R3", {stall, lp_req}, 2'b11, "stall and lp rise");
    repeat (4) @(negedge clk);
    store(32'h1080); chk("R4", stall, 1, "foreign granule store ignored");
    store(32'h1078); chk("R4", {stall, done}, 2'b01, "granule hit ends wait");

    cur_req = "R2"; issue(W_UNT);
    chk("R2", {stall, done}, 2'b01, "no reservation completes at once");
    irq_pend = 16'h0100; lr(32'h2000); issue(W_TIM);
    chk("R2", {stall, done}, 2'b01, "pending irq completes at once");
    irq_pend = '0;

    cur_req = "R12"; st_addr = 32'h2010; st_vld = 1; lr_addr = 32'h2000; lr_vld = 1;
    @(negedge clk); st_vld = 0; lr_vld = 0;
    issue(W_UNT); chk("R12", stall, 1, "lr wins over same-cycle hit");

    cur_req = "R5"; repeat (3) @(negedge clk);
    irq_pend = 16'h0020; @(negedge clk); irq_pend = '0;
    chk("R5", {stall, done}, 2'b01, "interrupt ends wait");

    cur_req = "R7"; priv = 2'd0; tw_m = 1; issue(W_TIM);
    chk("R12", stall, 1, "reservation survives completion");
    count_stall(n);
    chk("R7", n, STO, "timed wait length");
    chk("R7", {done, exc_vld}, 2'b10, "timed wait completes without trap");

    cur_req = "R6"; issue(W_UNT); repeat (2) @(negedge clk);
    wake_spur(); chk("R6", {stall, done}, 2'b01, "spurious wake ends wait");

    cur_req = "R8"; priv = 2'd1; tw_m = 1; issue(W_UNT);
    count_stall(n);
    chk("R8", n, TRAP, "untimed trap limit");
    chk("R8", {done, exc_vld, exc_cause}, {2'b01, 5'd2}, "illegal-instruction request");
    @(negedge clk); chk("R11", {done, exc_vld, exc_cause}, 0, "exception is one cycle");

    cur_req = "R9"; priv = 2'd0; tw_m = 0; virt = 1; vtw_h = 1; issue(W_UNT);
    count_stall(n);
    chk("R9", n, TRAP, "virtual trap limit");
    chk("R9", {exc_vld, exc_cause}, {1'b1, 5'd22}, "virtual-instruction request");

    cur_req = "R10"; virt = 0; vtw_h = 0; tw_m = 0; priv = 2'd0; issue(W_UNT);
    repeat (TRAP + 50) @(negedge clk);
    chk("R10", {stall, exc_vld}, 2'b10, "U mode with clear bits keeps waiting");
    wake_spur();
    priv = 2'd3; tw_m = 1; issue(W_UNT);
    repeat (TRAP + 50) @(negedge clk);
    chk("R10", {stall, exc_vld}, 2'b10, "M mode never traps");
    wake_spur(); chk("R11", {done, exc_vld}, 2'b10, "done alone at wake");

    cur_req = "R12"; priv = 2'd1; tw_m = 1; issue(W_UNT);
    repeat (TRAP - 1) @(negedge clk);
    irq_pend = 16'h0001; @(negedge clk); irq_pend = '0;
    chk("R12", {stall, done, exc_vld}, 3'b010, "release beats trap at limit");
    tw_m = 0; priv = 2'd0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule